// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block decides, for a single logical address, whether address translation can be skipped. It holds no windows of its own. Two 32-bit window descriptors come in as inputs, and the block compares the address against each of them. Each descriptor carries an enable bit, a base value for the top address byte, and a per-bit ignore mask for that byte. When an enabled window matches, the physical address is the logical address itself and the descriptor pointer is null. The table walker that follows can then skip its walk.

A requester pulses `reqValid` for one cycle with the address and both descriptors valid. One cycle later `respValid` pulses, and the registered result appears: a hit flag, the index of the winning window, the pass-through address and a zero descriptor pointer. Window 0 has priority over window 1. When no window hits, the walker must translate the address.

Top module: `ttWindowMatch`

## Requirements
- R1: After reset, `respValid`, `hitFlag`, `hitIndex`, `physAddr` and `descPtr` are all zero.
- R2: `respValid` is high in the cycle that follows a cycle with `reqValid` high, and is low at every other time.
- R3: A window takes part only when bit 15 of its descriptor is 1. A window whose bit 15 is 0 never produces a hit, whatever its other fields hold.
- R4: Descriptor bits 31:24 hold the base, which is compared bit by bit with address bits 31:24. When the mask is zero, a hit needs all eight bits to be equal.
- R5: Descriptor bits 23:16 hold the ignore mask. A 1 in mask bit k (descriptor bit 16+k) removes address bit 24+k from the compare. A mask of all ones therefore hits on any address.
- R6: Window 0 wins over window 1. When both windows hit, `hitIndex` is 0. `hitIndex` is 1 only when window 1 hits and window 0 does not.
- R7: On a hit, `physAddr` equals the requested address and `descPtr` is zero.
- R8: On a miss (no enabled window matches), `hitFlag` is 0, `hitIndex` is 0 and `physAddr` is 0.
- R9: Descriptor bits 14:0 and address bits 23:0 have no effect on whether a window hits.
- R10: Between requests, `hitFlag`, `hitIndex` and `physAddr` keep the values of the last request. The inputs may change freely while `reqValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | One-cycle request strobe |
| addrIn | input | 32 | Logical address to test |
| win0Reg | input | 32 | Window 0 descriptor (higher priority) |
| win1Reg | input | 32 | Window 1 descriptor |
| respValid | output | 1 | Result strobe, one cycle after the request |
| hitFlag | output | 1 | An enabled window matched |
| hitIndex | output | 1 | Index of the winning window |
| physAddr | output | 32 | Pass-through address on a hit, zero on a miss |
| descPtr | output | 32 | Descriptor pointer, null when the walk is bypassed |

## Verification
The hardest case to reach from the ports is a partial-mask match: some top-byte bits differ from the base, and every differing bit is covered by the mask. Purely random descriptors almost never produce this. The random stimulus therefore builds each base from the address's own top byte, flips a few bits, and then sets mask bits over some or all of the flipped positions. This yields near-misses and masked hits in roughly equal measure. Directed cases cover the case where both windows hit, the case where both windows are disabled but would otherwise match, and changes to the inputs between requests.

// File: rtl/ttWindowPkg.sv
package ttWindowPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;
  } ctlStrobes_t;
endpackage

// File: rtl/ttWindowCtl.sv
module ttWindowCtl
  import ttWindowPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output ctlStrobes_t strobes,
  output logic        respValid
);
  always_comb strobes.capture = reqValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) respValid <= 1'b0;
    else       respValid <= reqValid;
  end

  // R2: response follows every request by exactly one cycle
  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);
endmodule

// File: rtl/ttWindowDatapath.sv
module ttWindowDatapath
  import ttWindowPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CMP_W   = 8,
  parameter int NUM_WIN = 2,
  parameter int EN_BIT  = 15
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobes_t                    strobes,
  input  logic [ADDR_W-1:0]              addrIn,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] winRegs,
  output logic                           hitFlag,
  output logic [$clog2(NUM_WIN)-1:0]     hitIndex,
  output logic [ADDR_W-1:0]              physAddr
);
  localparam int IDX_W    = $clog2(NUM_WIN);
  localparam int BASE_LSB = ADDR_W - CMP_W;
  localparam int MASK_LSB = BASE_LSB - CMP_W;

  logic [NUM_WIN-1:0] winHit;
  logic               anyHit;
  logic [IDX_W-1:0]   winIdx;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [CMP_W-1:0] baseVal;
    logic [CMP_W-1:0] careMask;
    logic [CMP_W-1:0] diffBits;
    always_comb begin
      baseVal   = winRegs[w][ADDR_W-1:BASE_LSB];
      careMask  = ~winRegs[w][BASE_LSB-1:MASK_LSB];
      diffBits  = (addrIn[ADDR_W-1:BASE_LSB] ^ baseVal) & careMask;
      winHit[w] = winRegs[w][EN_BIT] && (diffBits == '0);
    end
  end

  // lowest index wins
  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (winHit[i]) begin
        anyHit = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitFlag  <= 1'b0;
      hitIndex <= '0;
      physAddr <= '0;
    end else if (strobes.capture) begin
      hitFlag  <= anyHit;
      hitIndex <= winIdx;
      physAddr <= anyHit ? addrIn : '0;
    end
  end

  // R7: a hit passes the requested address through
  assert_hit_passthru_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (!hitFlag || physAddr == $past(addrIn)));
  // R8: a miss leaves index and address at zero
  assert_miss_clean_R8: assert property (@(posedge clk) disable iff (!rstN)
    !hitFlag |-> (hitIndex == '0 && physAddr == '0));
  // R3: all windows disabled means no hit
  assert_disabled_nohit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !winRegs[0][EN_BIT] && !winRegs[NUM_WIN-1][EN_BIT])
      |=> !hitFlag);
  // R6: exact match on window 0 wins
  assert_win0_priority_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && winRegs[0][EN_BIT] &&
     winRegs[0][ADDR_W-1:BASE_LSB] == addrIn[ADDR_W-1:BASE_LSB])
      |=> (hitFlag && hitIndex == '0));
  // R10: results hold while idle
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(hitFlag) && $stable(hitIndex) && $stable(physAddr)));
endmodule

// File: rtl/ttWindowMatch.sv
module ttWindowMatch
  import ttWindowPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMP_W  = 8,
  parameter int EN_BIT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [ADDR_W-1:0] win0Reg,
  input  logic [ADDR_W-1:0] win1Reg,
  output logic              respValid,
  output logic              hitFlag,
  output logic              hitIndex,
  output logic [ADDR_W-1:0] physAddr,
  output logic [ADDR_W-1:0] descPtr
);
  localparam int NUM_WIN = 2;

  ctlStrobes_t                    strobes;
  logic [NUM_WIN-1:0][ADDR_W-1:0] winRegs;

  always_comb begin
    winRegs[0] = win0Reg;
    winRegs[1] = win1Reg;
    descPtr    = '0;
  end

  ttWindowCtl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .strobes   (strobes),
    .respValid (respValid)
  );

  ttWindowDatapath #(
    .ADDR_W  (ADDR_W),
    .CMP_W   (CMP_W),
    .NUM_WIN (NUM_WIN),
    .EN_BIT  (EN_BIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .addrIn   (addrIn),
    .winRegs  (winRegs),
    .hitFlag  (hitFlag),
    .hitIndex (hitIndex),
    .physAddr (physAddr)
  );
endmodule

// File: tb/ttWindowMatch_bench.sv
module ttWindowMatch_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] addrIn = '0, win0Reg = '0, win1Reg = '0;
  logic        respValid, hitFlag, hitIndex;
  logic [31:0] physAddr, descPtr;

  int testsRun = 0;
  int testsFailed = 0;
  bit watchdogHit = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ttWindowMatch u_ttWindowMatch (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .addrIn(addrIn),
    .win0Reg(win0Reg), .win1Reg(win1Reg), .respValid(respValid),
    .hitFlag(hitFlag), .hitIndex(hitIndex), .physAddr(physAddr), .descPtr(descPtr)
  );

  function automatic bit winMatch(input logic [31:0] w, input logic [31:0] a);
    return w[15] && (((a[31:24] ^ w[31:24]) & ~w[23:16]) == 8'h00);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, result is visible at the following negedge
  task automatic request(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1);
    @(negedge clk);
    addrIn = a; win0Reg = w0; win1Reg = w1; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic checkResult(input string req, input logic [31:0] a,
                             input logic [31:0] w0, input logic [31:0] w1);
    bit h0, h1, h;
    h0 = winMatch(w0, a);
    h1 = winMatch(w1, a);
    h  = h0 | h1;
    check({req, " respValid"}, 64'(respValid), 64'(1));
    check({req, " hitFlag"}, 64'(hitFlag), 64'(h));
    check({req, " hitIndex"}, 64'(hitIndex), 64'(!h0 && h1));
    check({req, " physAddr"}, 64'(physAddr), 64'(h ? a : 32'h0));
    check({req, " descPtr"}, 64'(descPtr), 64'(0));
  endtask

  function automatic logic [31:0] mkWin(input logic [7:0] base, input logic [7:0] mask,
                                        input bit en, input logic [14:0] low);
    return {base, mask, en, low};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    watchdogHit = 1'b1;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd12345);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 respValid", 64'(respValid), 64'(0));
    check("R1 hitFlag", 64'(hitFlag), 64'(0));
    check("R1 hitIndex", 64'(hitIndex), 64'(0));
    check("R1 physAddr", 64'(physAddr), 64'(0));
    check("R1 descPtr", 64'(descPtr), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    check("R2 idle no resp", 64'(respValid), 64'(0));

    // R4 exact match on window 1 only
    request(32'hA5123456, mkWin(8'h00, 8'h00, 1, 0), mkWin(8'hA5, 8'h00, 1, 0));
    checkResult("R4 exact win1", 32'hA5123456, mkWin(8'h00, 8'h00, 1, 0), mkWin(8'hA5, 8'h00, 1, 0));
    @(negedge clk);
    check("R2 one-cycle pulse", 64'(respValid), 64'(0));
    // R4 single bit off misses
    request(32'hA4000000, mkWin(8'hA5, 8'h00, 1, 0), mkWin(8'h25, 8'h00, 1, 0));
    checkResult("R4 near miss", 32'hA4000000, mkWin(8'hA5, 8'h00, 1, 0), mkWin(8'h25, 8'h00, 1, 0));
    check("R8 miss", 64'({hitFlag, hitIndex, physAddr}), 64'(0));
    // R5 masked bit makes it hit
    request(32'hA4000000, mkWin(8'hA5, 8'h01, 1, 0), 32'h0);
    checkResult("R5 masked hit", 32'hA4000000, mkWin(8'hA5, 8'h01, 1, 0), 32'h0);
    request(32'h3C0000FF, mkWin(8'h00, 8'hFF, 1, 0), 32'h0);
    check("R5 full mask", 64'(hitFlag), 64'(1));
    // R3 disabled windows that would match
    request(32'h80000000, mkWin(8'h80, 8'hFF, 0, 15'h7FFF), mkWin(8'h80, 8'h00, 0, 0));
    check("R3 disabled", 64'(hitFlag), 64'(0));
    // R6 both hit -> index 0
    request(32'h40001000, mkWin(8'h40, 8'h00, 1, 0), mkWin(8'h00, 8'hFF, 1, 0));
    check("R6 both hit idx", 64'({hitFlag, hitIndex}), 64'(2'b10));
    // R7 passthrough
    check("R7 physAddr", 64'(physAddr), 64'(32'h40001000));
    check("R7 descPtr", 64'(descPtr), 64'(0));
    // R9 low bits of descriptor and address irrelevant
    request(32'h40FFFFFF, mkWin(8'h40, 8'h00, 1, 15'h7FFF), 32'h0);
    check("R9 low bits", 64'({hitFlag, physAddr}), 64'({1'b1, 32'h40FFFFFF}));
    // R10 hold while inputs change without a request
    @(negedge clk);
    addrIn = 32'h11111111; win0Reg = 32'h0; win1Reg = 32'h0;
    repeat (3) @(negedge clk);
    check("R10 hold", 64'({hitFlag, hitIndex, physAddr}), 64'({1'b1, 1'b0, 32'h40FFFFFF}));

    // constrained random: bases near the address, masks over flipped bits
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, w0, w1;
      logic [7:0] f0, f1;
      a  = $urandom;
      f0 = 8'($urandom) & 8'($urandom);
      f1 = 8'($urandom) & 8'($urandom);
      w0 = mkWin(a[31:24] ^ f0, f0 & 8'($urandom | $urandom), 1'($urandom_range(0, 3) != 0), 15'($urandom));
      w1 = mkWin(a[31:24] ^ f1, f1 & 8'($urandom | $urandom), 1'($urandom_range(0, 3) != 0), 15'($urandom));
      request(a, w0, w1);
      checkResult("R4 R5 R6 random", a, w0, w1);
      if (watchdogHit) break;
    end

    if (watchdogHit) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=expired expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule